// File: doc/BRIEF.md
# Single-Precision Floating-Point Compare Unit

This block compares two IEEE 754 single-precision operands held in 32-bit general-purpose register words. A 3-bit predicate select picks one of seven relations. The outcome is a 32-bit boolean word, either 1 or 0, that is ready to be written back to the register file. The operands are sampled on an issue strobe. One clock edge later the unit presents the result word, a valid pulse and a write-enable.

The unit sorts each operand into one of these classes: ordinary, zero, denormal, quiet NaN or signalling NaN. When the exception-enable input is high, an operand class the compare cannot accept sets an invalid-operation flag or a denormal-operand flag. Either flag holds the write-enable low, so the destination register keeps its old value. The result word is still computed. Redirecting the processor to an exception handler is outside this block; the unit only reports the condition.

Top module: `fpcmp_unit`

## Requirements
- R1: `opSel` encodes the predicate as follows: 0 less-than, 1 equal, 2 less-or-equal, 3 greater-than, 4 not-equal, 5 greater-or-equal, 6 unordered. Code 7 is reserved. It returns 0 and is not treated as an ordered predicate.
- R2: Operands, predicate and `excEnable` are sampled at the clock edge where `inValid` is high. `outValid` is high for exactly the following cycle. While no operation is issued, `result` keeps its last value.
- R3: `result` is 32'h1 when the predicate holds and 32'h0 when it does not. Bits 31..1 are always zero.
- R4: Non-NaN values are ordered by sign and magnitude, where magnitude is bits 30..0. For two negative values, the one with the larger magnitude is the smaller value. Any negative value is below any positive value. Infinities (exponent 0xFF, fraction 0) are ordinary values at the two ends of the range.
- R5: +0 (32'h00000000) and -0 (32'h80000000) compare equal.
- R6: A NaN has exponent bits 30..23 all ones and a nonzero fraction. If either operand is a NaN, then less-than, equal, less-or-equal, greater-than and greater-or-equal return 0, while not-equal and unordered return 1.
- R7: With `excEnable` high, `excInvalid` is raised in two cases. The first is any NaN operand under predicate 0, 2, 3 or 5. The second is a signalling NaN operand (fraction bit 22 clear) under any predicate.
- R8: With `excEnable` high, `excDenorm` is raised if either operand is denormal, meaning exponent 0 with a nonzero fraction. Denormal values are still ordered by R4.
- R9: When `excInvalid` or `excDenorm` is raised, `wrEn` stays low while `outValid` and `result` are still produced.
- R10: With `excEnable` low, no exception flag is raised, and `wrEn` follows `outValid` for every predicate and operand class.
- R11: After reset, `outValid`, `wrEn`, both exception flags and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Issue strobe for one compare |
| opSel | input | 3 | Predicate select (R1) |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| excEnable | input | 1 | Enables exception reporting |
| outValid | output | 1 | Result is valid this cycle |
| wrEn | output | 1 | Destination register write-enable |
| result | output | 32 | Boolean result word |
| excInvalid | output | 1 | Invalid-operation exception |
| excDenorm | output | 1 | Denormal-operand exception |

## Verification
Every output (`result`, `outValid`, `wrEn` and both flags) comes from a single register stage. Each one therefore belongs to the operation issued at the previous rising edge. The bench drives an operation on a falling edge and removes the strobe at the next falling edge. It reads all outputs at that same falling edge, half a cycle after the capturing edge, and compares them against a model that orders values through sign-flipped integer keys. A hold scenario reads the outputs again one cycle later to confirm that `outValid` has dropped and `result` is unchanged.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

  typedef enum logic [2:0] {
    CMP_LT  = 3'd0,
    CMP_EQ  = 3'd1,
    CMP_LE  = 3'd2,
    CMP_GT  = 3'd3,
    CMP_NE  = 3'd4,
    CMP_GE  = 3'd5,
    CMP_UN  = 3'd6,
    CMP_RSV = 3'd7
  } cmpOp_e;

  // relations produced by the datapath for the control
  typedef struct packed {
    logic unord;
    logic lt;
    logic eq;
    logic anySnan;
    logic anyDenorm;
  } cmpRel_t;

  // strobes sent by the control to the datapath
  typedef struct packed {
    logic load;
    logic resBit;
  } cmpStrobe_t;

endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] opnd,
  output logic                 isNan,
  output logic                 isSnan,
  output logic                 isDenorm,
  output logic                 isZero
);
  logic [EXP_W-1:0] expField;
  logic [MAN_W-1:0] manField;
  logic expAllOnes;
  logic expAllZero;
  logic manNonZero;

  assign expField   = opnd[EXP_W+MAN_W-1:MAN_W];
  assign manField   = opnd[MAN_W-1:0];
  assign expAllOnes = &expField;
  assign expAllZero = ~|expField;
  assign manNonZero = |manField;

  assign isNan    = expAllOnes & manNonZero;
  assign isSnan   = isNan & ~manField[MAN_W-1];
  assign isDenorm = expAllZero & manNonZero;
  assign isZero   = expAllZero & ~manNonZero;
endmodule

// File: rtl/fpcmp_datapath.sv
module fpcmp_datapath
  import fpcmp_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [EXP_W+MAN_W:0] opA,
  input  logic [EXP_W+MAN_W:0] opB,
  input  cmpStrobe_t           strb,
  output cmpRel_t              rel,
  output logic [EXP_W+MAN_W:0] result
);
  localparam int W      = 1 + EXP_W + MAN_W;
  localparam int N_OPND = 2;

  logic [W-1:0] opnd [N_OPND];
  logic [N_OPND-1:0] nanV, snanV, denV, zeroV;

  assign opnd[0] = opA;
  assign opnd[1] = opB;

  for (genvar i = 0; i < N_OPND; i++) begin : g_cls
    fpcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .opnd    (opnd[i]),
      .isNan   (nanV[i]),
      .isSnan  (snanV[i]),
      .isDenorm(denV[i]),
      .isZero  (zeroV[i])
    );
  end

  logic signA, signB;
  logic [W-2:0] magA, magB;
  logic bothZero, sameWord, eqRaw, ltRaw, unord;

  assign signA    = opA[W-1];
  assign signB    = opB[W-1];
  assign magA     = opA[W-2:0];
  assign magB     = opB[W-2:0];
  assign bothZero = &zeroV;
  assign sameWord = (opA == opB);
  assign eqRaw    = bothZero | sameWord;
  assign unord    = |nanV;

  always_comb begin
    if (signA != signB) ltRaw = signA;
    else if (signA)     ltRaw = (magA > magB);
    else                ltRaw = (magA < magB);
  end

  assign rel.unord     = unord;
  assign rel.eq        = ~unord & eqRaw;
  assign rel.lt        = ~unord & ~eqRaw & ltRaw;
  assign rel.anySnan   = |snanV;
  assign rel.anyDenorm = |denV;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         result <= '0;
    else if (strb.load) result <= {{(W-1){1'b0}}, strb.resBit};
  end
endmodule

// File: rtl/fpcmp_control.sv
module fpcmp_control
  import fpcmp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inValid,
  input  logic [2:0] opSel,
  input  logic       excEnable,
  input  cmpRel_t    rel,
  output cmpStrobe_t strb,
  output logic       outValid,
  output logic       wrEn,
  output logic       excInvalid,
  output logic       excDenorm
);
  cmpOp_e op;
  logic   predBit;
  logic   orderedOp;
  logic   raiseInv, raiseDen;

  assign op = cmpOp_e'(opSel);

  always_comb begin
    predBit   = 1'b0;
    orderedOp = 1'b0;
    unique case (op)
      CMP_LT:  begin predBit = rel.lt;                       orderedOp = 1'b1; end
      CMP_EQ:  predBit = rel.eq;
      CMP_LE:  begin predBit = rel.lt | rel.eq;              orderedOp = 1'b1; end
      CMP_GT:  begin predBit = ~rel.lt & ~rel.eq & ~rel.unord; orderedOp = 1'b1; end
      CMP_NE:  predBit = ~rel.eq;
      CMP_GE:  begin predBit = ~rel.lt & ~rel.unord;         orderedOp = 1'b1; end
      CMP_UN:  predBit = rel.unord;
      CMP_RSV: predBit = 1'b0;
      default: predBit = 1'b0;
    endcase
  end

  assign raiseInv = excEnable & ((orderedOp & rel.unord) | rel.anySnan);
  assign raiseDen = excEnable & rel.anyDenorm;

  assign strb.load   = inValid;
  assign strb.resBit = predBit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid   <= 1'b0;
      wrEn       <= 1'b0;
      excInvalid <= 1'b0;
      excDenorm  <= 1'b0;
    end else begin
      outValid   <= inValid;
      wrEn       <= inValid & ~raiseInv & ~raiseDen;
      excInvalid <= inValid & raiseInv;
      excDenorm  <= inValid & raiseDen;
    end
  end
endmodule

// File: rtl/fpcmp_unit.sv
module fpcmp_unit
  import fpcmp_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 inValid,
  input  logic [2:0]           opSel,
  input  logic [EXP_W+MAN_W:0] opA,
  input  logic [EXP_W+MAN_W:0] opB,
  input  logic                 excEnable,
  output logic                 outValid,
  output logic                 wrEn,
  output logic [EXP_W+MAN_W:0] result,
  output logic                 excInvalid,
  output logic                 excDenorm
);
  cmpRel_t    rel;
  cmpStrobe_t strb;

  fpcmp_datapath #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_dp (
    .clk   (clk),
    .rst_n (rst_n),
    .opA   (opA),
    .opB   (opB),
    .strb  (strb),
    .rel   (rel),
    .result(result)
  );

  fpcmp_control u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .inValid   (inValid),
    .opSel     (opSel),
    .excEnable (excEnable),
    .rel       (rel),
    .strb      (strb),
    .outValid  (outValid),
    .wrEn      (wrEn),
    .excInvalid(excInvalid),
    .excDenorm (excDenorm)
  );
endmodule

// File: rtl/fpcmp_unit_checker.sv
module fpcmp_unit_checker #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 inValid,
  input logic [2:0]           opSel,
  input logic [EXP_W+MAN_W:0] opA,
  input logic [EXP_W+MAN_W:0] opB,
  input logic                 excEnable,
  input logic                 outValid,
  input logic                 wrEn,
  input logic [EXP_W+MAN_W:0] result,
  input logic                 excInvalid,
  input logic                 excDenorm
);
  localparam int W = 1 + EXP_W + MAN_W;

  logic aNan, aDen;
  assign aNan = (&opA[W-2:MAN_W]) & (|opA[MAN_W-1:0]);
  assign aDen = ~(|opA[W-2:MAN_W]) & (|opA[MAN_W-1:0]);

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid);

  a_r2_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> $stable(result));

  a_r3_boolean_word: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> (result[W-1:1] == '0));

  a_r6_unord_nan: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && opSel == 3'd6 && aNan) |=> result[0]);

  a_r8_denorm_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && excEnable && aDen) |=> excDenorm);

  a_r9_exc_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
    (excInvalid || excDenorm) |-> (!wrEn && outValid));

  a_r9_write_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn |-> outValid);

  a_r10_disabled_writes: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && !excEnable) |=> (wrEn && !excInvalid && !excDenorm));
endmodule

bind fpcmp_unit fpcmp_unit_checker #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .inValid   (inValid),
  .opSel     (opSel),
  .opA       (opA),
  .opB       (opB),
  .excEnable (excEnable),
  .outValid  (outValid),
  .wrEn      (wrEn),
  .result    (result),
  .excInvalid(excInvalid),
  .excDenorm (excDenorm)
);

// File: tb/fpcmp_unit_tb.sv
module fpcmp_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic [2:0]  opSel = 3'd0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic        excEnable = 1'b0;
  logic        outValid, wrEn, excInvalid, excDenorm;
  logic [31:0] result;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  fpcmp_unit u_dut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .opSel(opSel),
    .opA(opA), .opB(opB), .excEnable(excEnable), .outValid(outValid),
    .wrEn(wrEn), .result(result), .excInvalid(excInvalid), .excDenorm(excDenorm)
  );

  function automatic logic isNanW(input logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction

  function automatic logic [31:0] orderKey(input logic [31:0] x);
    if (x[30:0] == 0) return 32'h8000_0000;
    return x[31] ? ~x : (x | 32'h8000_0000);
  endfunction

  // returns {resultBit, wrEn, excInvalid, excDenorm}
  function automatic logic [3:0] refEval(input logic [2:0] op, input logic [31:0] a,
                                         input logic [31:0] b, input logic en);
    logic un, lt, eq, gt, r, sn, inv, den, ordered;
    un = isNanW(a) | isNanW(b);
    lt = !un && orderKey(a) <  orderKey(b);
    eq = !un && orderKey(a) == orderKey(b);
    gt = !un && orderKey(a) >  orderKey(b);
    case (op)
      3'd0: r = lt;
      3'd1: r = eq;
      3'd2: r = lt | eq;
      3'd3: r = gt;
      3'd4: r = !eq;
      3'd5: r = gt | eq;
      3'd6: r = un;
      default: r = 1'b0;
    endcase
    ordered = (op == 3'd0) || (op == 3'd2) || (op == 3'd3) || (op == 3'd5);
    sn  = (isNanW(a) && !a[22]) || (isNanW(b) && !b[22]);
    inv = en && ((ordered && un) || sn);
    den = en && (((a[30:23] == 0) && (a[22:0] != 0)) || ((b[30:23] == 0) && (b[22:0] != 0)));
    return {r, !(inv | den), inv, den};
  endfunction

  task automatic doOp(input string req, input logic [2:0] op, input logic [31:0] a,
                      input logic [31:0] b, input logic en);
    logic [3:0] exp4;
    logic [35:0] got, want;
    exp4 = refEval(op, a, b, en);
    @(negedge clk);
    inValid = 1'b1; opSel = op; opA = a; opB = b; excEnable = en;
    @(negedge clk);
    inValid = 1'b0;
    want = {32'(exp4[3]), 1'b1, exp4[2], exp4[1], exp4[0]};
    got  = {result, outValid, wrEn, excInvalid, excDenorm};
    nChecks++;
    if (got !== want) begin
      nFails++;
      $display("FAIL %s op=%0d a=%h b=%h en=%0b: got res=%h v=%0b wr=%0b inv=%0b den=%0b, expected res=%h v=1 wr=%0b inv=%0b den=%0b",
               req, op, a, b, en, result, outValid, wrEn, excInvalid, excDenorm,
               32'(exp4[3]), exp4[2], exp4[1], exp4[0]);
    end
  endtask

  task automatic checkReset();
    nChecks++;
    if ({result, outValid, wrEn, excInvalid, excDenorm} !== 36'h0) begin
      nFails++;
      $display("FAIL R11 after reset: got res=%h v=%0b wr=%0b inv=%0b den=%0b, expected all zero",
               result, outValid, wrEn, excInvalid, excDenorm);
    end
  endtask

  task automatic testPredicates();  // R1, R3
    for (int k = 0; k < 8; k++) begin
      doOp("R1", 3'(k), 32'h3F80_0000, 32'h4000_0000, 1'b1);
      doOp("R3", 3'(k), 32'h4000_0000, 32'h4000_0000, 1'b1);
    end
  endtask

  task automatic testOrdering();  // R4
    doOp("R4", 3'd0, 32'hBF80_0000, 32'hC000_0000, 1'b1);
    doOp("R4", 3'd3, 32'hBF80_0000, 32'hC000_0000, 1'b1);
    doOp("R4", 3'd0, 32'hC000_0000, 32'h3F80_0000, 1'b1);
    doOp("R4", 3'd5, 32'h7F80_0000, 32'h7F7F_FFFF, 1'b1);
    doOp("R4", 3'd2, 32'hFF80_0000, 32'hFF7F_FFFF, 1'b1);
    doOp("R4", 3'd0, 32'h3F80_0000, 32'h3F80_0001, 1'b1);
  endtask

  task automatic testZeros();  // R5
    doOp("R5", 3'd1, 32'h0000_0000, 32'h8000_0000, 1'b1);
    doOp("R5", 3'd0, 32'h8000_0000, 32'h0000_0000, 1'b1);
    doOp("R5", 3'd4, 32'h0000_0000, 32'h8000_0000, 1'b1);
    doOp("R5", 3'd5, 32'h0000_0000, 32'h8000_0000, 1'b1);
  endtask

  task automatic testNan();  // R6, R7
    doOp("R6", 3'd1, 32'h7FC0_0000, 32'h3F80_0000, 1'b1);
    doOp("R6", 3'd4, 32'h3F80_0000, 32'h7FC0_0000, 1'b1);
    doOp("R6", 3'd6, 32'h7FC0_0000, 32'h7FC0_0000, 1'b1);
    doOp("R6", 3'd1, 32'h7FC0_0000, 32'h7FC0_0000, 1'b1);
    doOp("R7", 3'd0, 32'h7FC0_0000, 32'h3F80_0000, 1'b1);
    doOp("R7", 3'd5, 32'h3F80_0000, 32'hFFC0_0001, 1'b1);
    doOp("R7", 3'd1, 32'h7F80_0001, 32'h3F80_0000, 1'b1);
    doOp("R7", 3'd6, 32'h3F80_0000, 32'h7F80_0001, 1'b1);
  endtask

  task automatic testDenorm();  // R8, R9
    doOp("R8", 3'd3, 32'h0000_0001, 32'h0000_0000, 1'b1);
    doOp("R8", 3'd0, 32'h3F80_0000, 32'h807F_FFFF, 1'b1);
    doOp("R9", 3'd0, 32'h7F80_0001, 32'h0000_0002, 1'b1);
  endtask

  task automatic testDisabled();  // R10
    doOp("R10", 3'd0, 32'h7FC0_0000, 32'h3F80_0000, 1'b0);
    doOp("R10", 3'd1, 32'h7F80_0001, 32'h7F80_0001, 1'b0);
    doOp("R10", 3'd3, 32'h0000_0001, 32'h0000_0000, 1'b0);
  endtask

  task automatic testHold();  // R2
    logic [31:0] held;
    doOp("R2", 3'd0, 32'h3F80_0000, 32'h4000_0000, 1'b1);
    held = result;
    @(negedge clk);
    opA = 32'h4000_0000; opB = 32'h3F80_0000; opSel = 3'd0;
    @(negedge clk);
    nChecks++;
    if (outValid !== 1'b0 || wrEn !== 1'b0 || result !== held) begin
      nFails++;
      $display("FAIL R2 idle cycle: got v=%0b wr=%0b res=%h, expected v=0 wr=0 res=%h",
               outValid, wrEn, result, held);
    end
  endtask

  initial begin
    #(20 * 150000);
    nFails++;
    $display("FAIL watchdog: run did not finish, got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checkReset();
    rst_n = 1'b1;
    testPredicates();
    testOrdering();
    testZeros();
    testNan();
    testDenorm();
    testDisabled();
    testHold();
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule